// File: doc/BRIEF.md
# Pre-settling SAR Conversion Controller

This block sequences an 8-bit successive-approximation conversion that drives three capacitive DACs, each with its own comparator. At any moment during a conversion one DAC is being compared. The other two are already loaded with the codes the next bit will need: one for a decision of 1 and one for a decision of 0. When the comparator reports, the controller hands the next comparison to the DAC that already holds the matching code, so the next bit never waits for a DAC to settle.

A start request ends sampling and launches the conversion. Each comparator decision arrives on a per-comparator input together with a shared done strobe. The controller answers with a one-hot select of the comparator/DAC pair to use, the three DAC codes, and finally the 8-bit result with a one-cycle valid flag. The analog side, including comparator timing, is outside the block.

Top module: `presettle_sar_ctrl`

## Requirements
- R1: After reset, `cmp_sel_o` is 000, all three DAC codes are 0 and `result_valid_o` is 0.
- R2: Whenever no conversion runs (the sampling state), all three DAC codes are 0. A `start_i` seen while idle starts a conversion one cycle later with DAC0 active (`cmp_sel_o` = 001), DAC0 code 0x80, DAC1 code 0xC0 and DAC2 code 0x40.
- R3: During a conversion `cmp_sel_o` has exactly one bit set, where bit i selects DAC i. When idle it is 000.
- R4: The decision is the OR of `cmp_dec_i` bits masked by `cmp_sel_o`, taken in a cycle where `cmp_done_i` is 1. Inputs of unselected comparators have no effect on the result.
- R5: One cycle after a decision that is not the last, the DAC that held the high preset becomes active if the decision was 1. Otherwise the DAC that held the low preset becomes active. The newly active DAC's code does not change at the hand-over.
- R6: With P the resolved bits above bit k and the bit k under test, the codes are: active = P | 2^k; high preset = P | 2^k | 2^(k-1); low preset = P | 2^(k-1). The 2^(k-1) term is dropped for k = 0. After a hand-over, the previously active DAC takes the high-preset role and the losing preset DAC takes the low-preset role.
- R7: Bits are decided MSB first over eight decisions. In the cycle after the eighth decision, `result_valid_o` is 1 for exactly one cycle with `result_o` holding the result, `cmp_sel_o` returns to 000 and the codes return to 0.
- R8: `start_i` during a conversion is ignored. `cmp_done_i` while idle is ignored.
- R9: While no decision strobe arrives, the selection and all DAC codes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | End of sampling / start of conversion |
| cmp_done_i | input | 1 | Comparator decision strobe |
| cmp_dec_i | input | 3 | Decision of each comparator, bit i for DAC i |
| cmp_sel_o | output | 3 | One-hot active comparator/DAC select |
| dac_code_o | output | 24 | DAC codes, DAC i at bits [8i+7:8i] |
| result_o | output | 8 | Conversion result |
| result_valid_o | output | 1 | Result valid pulse |

## Verification
A corrupted role map shows up at the ports in the cycle after the decision that hands over the comparison. Either the select points at a DAC whose code is not the expected trial code, or the masked decision is lost, and the final code then differs from the input level. A wrong preset code is visible on the DAC bus as soon as it is loaded, one bit before it would be compared. The bench therefore compares every code on every step, and varies the gaps between strobes, the noise on unselected comparators and stray start pulses, so that hold and masking faults cannot hide.

// File: rtl/presettle_sar_pkg.sv
package presettle_sar_pkg;
  localparam int unsigned NUM_DAC = 3;
  typedef enum logic [1:0] {
    ROLE_IDLE = 2'd0,
    ROLE_ACT  = 2'd1,
    ROLE_HI   = 2'd2,
    ROLE_LO   = 2'd3
  } dac_role_e;
endpackage

// File: rtl/sar_bit_seq.sv
module sar_bit_seq #(
  parameter int unsigned N_BITS = 8,
  localparam int unsigned IW = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              dec_i,
  output logic              launch_o,
  output logic              decide_o,
  output logic              last_o,
  output logic [IW-1:0]     next_idx_o,
  output logic [N_BITS-1:0] next_part_o,
  output logic [N_BITS-1:0] result_o,
  output logic              valid_o
);
  logic              busy_q, valid_q;
  logic [IW-1:0]     idx_q;
  logic [N_BITS-1:0] part_q;

  assign launch_o = start_i & ~busy_q;
  assign decide_o = done_i & busy_q;
  assign last_o   = decide_o & (idx_q == '0);

  always_comb begin
    next_part_o = part_q;
    if (launch_o)      next_part_o = '0;
    else if (decide_o) next_part_o[idx_q] = dec_i;
    next_idx_o = launch_o ? IW'(N_BITS - 1) : idx_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
      part_q  <= '0;
    end else begin
      valid_q <= last_o;
      if (launch_o)    busy_q <= 1'b1;
      else if (last_o) busy_q <= 1'b0;
      if (launch_o || decide_o) begin
        part_q <= next_part_o;
        idx_q  <= next_idx_o;
      end
    end
  end

  assign result_o = part_q;
  assign valid_o  = valid_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R7
  AST_LAST_GIVES_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (valid_q && !busy_q)); // R7
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !done_i) |=> (busy_q && $stable(idx_q) && $stable(part_q))); // R8
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && done_i && !start_i) |=> (!busy_q && !valid_q)); // R8
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> ($stable(idx_q) && $stable(part_q))); // R9
endmodule

// File: rtl/sar_role_map.sv
module sar_role_map
  import presettle_sar_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic               decide_i,
  input  logic               last_i,
  input  logic               dec_i,
  output dac_role_e          role_o      [NUM_DAC],
  output dac_role_e          next_role_o [NUM_DAC],
  output logic [NUM_DAC-1:0] sel_o
);
  dac_role_e role_q [NUM_DAC];

  for (genvar i = 0; i < NUM_DAC; i++) begin : g_slot
    always_comb begin
      next_role_o[i] = role_q[i];
      if (launch_i) begin
        next_role_o[i] = (i == 0) ? ROLE_ACT : (i == 1) ? ROLE_HI : ROLE_LO;
      end else if (last_i) begin
        next_role_o[i] = ROLE_IDLE;
      end else if (decide_i) begin
        unique case (role_q[i])
          ROLE_ACT: next_role_o[i] = ROLE_HI;
          ROLE_HI:  next_role_o[i] = dec_i ? ROLE_ACT : ROLE_LO;
          ROLE_LO:  next_role_o[i] = dec_i ? ROLE_LO : ROLE_ACT;
          default:  next_role_o[i] = ROLE_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) role_q[i] <= ROLE_IDLE;
      else         role_q[i] <= next_role_o[i];
    end

    assign role_o[i] = role_q[i];
    assign sel_o[i]  = (role_q[i] == ROLE_ACT);
  end

  AST_SEL_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R3
  AST_LAUNCH_SELECTS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (sel_o == 3'b001)); // R2
  AST_HANDOVER_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !last_i) |=> ($countones(sel_o) == 1 && sel_o != $past(sel_o))); // R5
endmodule

// File: rtl/sar_dac_slot.sv
module sar_dac_slot
  import presettle_sar_pkg::*;
#(
  parameter int unsigned N_BITS = 8,
  localparam int unsigned IW = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  dac_role_e         role_i,
  input  dac_role_e         next_role_i,
  input  logic [N_BITS-1:0] next_part_i,
  input  logic [IW-1:0]     next_idx_i,
  output logic [N_BITS-1:0] code_o
);
  localparam logic [N_BITS-1:0] ONE = N_BITS'(1);

  logic [N_BITS-1:0] code_q, code_d, bit_k, bit_trial;

  always_comb begin
    bit_k     = ONE << next_idx_i;
    bit_trial = (next_idx_i != '0) ? (ONE << (next_idx_i - 1'b1)) : '0;
    unique case (next_role_i)
      ROLE_ACT: code_d = next_part_i | bit_k;
      ROLE_HI:  code_d = next_part_i | bit_k | bit_trial;
      ROLE_LO:  code_d = next_part_i | bit_trial;
      default:  code_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (load_i) code_q <= code_d;
  end

  assign code_o = code_q;

  AST_ACTIVE_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && next_role_i == ROLE_ACT && role_i != ROLE_IDLE) |=> $stable(code_q)); // R5
  AST_NO_LOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_q)); // R9
endmodule

// File: rtl/presettle_sar_ctrl.sv
module presettle_sar_ctrl
  import presettle_sar_pkg::*;
#(
  parameter int unsigned N_BITS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        cmp_done_i,
  input  logic [NUM_DAC-1:0]          cmp_dec_i,
  output logic [NUM_DAC-1:0]          cmp_sel_o,
  output logic [NUM_DAC*N_BITS-1:0]   dac_code_o,
  output logic [N_BITS-1:0]           result_o,
  output logic                        result_valid_o
);
  localparam int unsigned IW = (N_BITS > 1) ? $clog2(N_BITS) : 1;

  logic              launch, decide, last, dec;
  logic [IW-1:0]     next_idx;
  logic [N_BITS-1:0] next_part;
  dac_role_e         role [NUM_DAC];
  dac_role_e         next_role [NUM_DAC];

  // merged decision stream: only the enabled comparator counts
  assign dec = |(cmp_dec_i & cmp_sel_o);

  sar_bit_seq #(.N_BITS(N_BITS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .done_i      (cmp_done_i),
    .dec_i       (dec),
    .launch_o    (launch),
    .decide_o    (decide),
    .last_o      (last),
    .next_idx_o  (next_idx),
    .next_part_o (next_part),
    .result_o    (result_o),
    .valid_o     (result_valid_o)
  );

  sar_role_map u_roles (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .decide_i    (decide),
    .last_i      (last),
    .dec_i       (dec),
    .role_o      (role),
    .next_role_o (next_role),
    .sel_o       (cmp_sel_o)
  );

  for (genvar i = 0; i < NUM_DAC; i++) begin : g_dac
    sar_dac_slot #(.N_BITS(N_BITS)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (launch | decide),
      .role_i      (role[i]),
      .next_role_i (next_role[i]),
      .next_part_i (next_part),
      .next_idx_i  (next_idx),
      .code_o      (dac_code_o[i*N_BITS +: N_BITS])
    );
  end

  AST_IDLE_CODES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_sel_o == '0) |-> (dac_code_o == '0)); // R2
  AST_VALID_ENDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (cmp_sel_o == '0)); // R7
endmodule

// File: tb/presettle_sar_ctrl_test.sv
module presettle_sar_ctrl_test;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_done_i = 1'b0;
  logic [2:0]    cmp_dec_i = 3'b000;
  logic [2:0]    cmp_sel_o;
  logic [3*NB-1:0] dac_code_o;
  logic [NB-1:0] result_o;
  logic          result_valid_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;

  presettle_sar_ctrl #(.N_BITS(NB)) uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .cmp_done_i     (cmp_done_i),
    .cmp_dec_i      (cmp_dec_i),
    .cmp_sel_o      (cmp_sel_o),
    .dac_code_o     (dac_code_o),
    .result_o       (result_o),
    .result_valid_o (result_valid_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int code_of(int slot, int dacs);
    return (dacs >> (slot * NB)) & 8'hFF;
  endfunction

  // monitor: pop the expected result whenever the design presents one
  always @(negedge clk) begin
    if (rst_ni && result_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected valid", result_o, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(result_o == e[NB-1:0], "R7 result", result_o, e);
      end
    end
  end

  task automatic check_codes(int act, int hi, int lo, int part, int k, string req);
    int ca, ch, cl;
    ca = part | (1 << k);
    ch = part | (1 << k) | ((k > 0) ? (1 << (k - 1)) : 0);
    cl = part | ((k > 0) ? (1 << (k - 1)) : 0);
    check(cmp_sel_o == 3'(1 << act), {"R3 select ", req}, cmp_sel_o, 1 << act);
    check(code_of(act, int'(dac_code_o)) == ca, {"R6 active code ", req}, code_of(act, int'(dac_code_o)), ca);
    check(code_of(hi, int'(dac_code_o)) == ch, {"R6 high preset ", req}, code_of(hi, int'(dac_code_o)), ch);
    check(code_of(lo, int'(dac_code_o)) == cl, {"R6 low preset ", req}, code_of(lo, int'(dac_code_o)), cl);
  endtask

  // driver: one conversion of level vin, comparator modelled here
  task automatic convert(int vin, int gap, bit poke, bit noise);
    int act, hi, lo, part, nact, loser;
    bit d;
    logic [3*NB-1:0] held;
    exp_q.push_back(vin);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    act = 0; hi = 1; lo = 2; part = 0;
    check(cmp_sel_o == 3'b001 && dac_code_o == {8'h40, 8'hC0, 8'h80},
          "R2 launch state", int'(dac_code_o), 24'h40C080);
    for (int k = NB - 1; k >= 0; k--) begin
      check_codes(act, hi, lo, part, k, "step");
      held = dac_code_o;
      for (int g = 0; g < gap; g++) begin
        start_i = poke;
        @(negedge clk);
        check(dac_code_o == held, "R9 hold codes", int'(dac_code_o), int'(held));
        if (poke) check(cmp_sel_o == 3'(1 << act), "R8 start ignored", cmp_sel_o, 1 << act);
      end
      start_i = 1'b0;
      d = (vin >= (part | (1 << k)));
      cmp_dec_i = noise ? {3{~d}} : 3'b000;
      cmp_dec_i[act] = d;
      cmp_done_i = 1'b1;
      @(negedge clk);
      cmp_done_i = 1'b0;
      cmp_dec_i = 3'b000;
      if (d) part = part | (1 << k);
      if (k > 0) begin
        nact = d ? hi : lo;
        loser = d ? lo : hi;
        check(code_of(nact, int'(dac_code_o)) == code_of(nact, int'(held)),
              "R5 handover code held", code_of(nact, int'(dac_code_o)), code_of(nact, int'(held)));
        hi = act; lo = loser; act = nact;
      end
    end
    check(result_valid_o == 1'b1, "R7 valid after eighth", result_valid_o, 1);
    check(cmp_sel_o == 3'b000, "R7 select cleared", cmp_sel_o, 0);
    check(dac_code_o == '0, "R2 sampling codes", int'(dac_code_o), 0);
    @(negedge clk);
    check(result_valid_o == 1'b0, "R7 valid one cycle", result_valid_o, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmp_sel_o == 3'b000, "R1 reset select", cmp_sel_o, 0);
    check(dac_code_o == '0, "R1 reset codes", int'(dac_code_o), 0);
    check(result_valid_o == 1'b0, "R1 reset valid", result_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // strobe while idle: R8
    cmp_done_i = 1'b1;
    cmp_dec_i = 3'b111;
    @(negedge clk);
    cmp_done_i = 1'b0;
    cmp_dec_i = 3'b000;
    @(negedge clk);
    check(result_valid_o == 1'b0 && cmp_sel_o == 3'b000, "R8 idle strobe ignored",
          {cmp_sel_o, result_valid_o}, 0);
    convert(8'h00, 0, 1'b0, 1'b0);
    convert(8'hFF, 0, 1'b0, 1'b1);  // R4 noisy unselected comparators
    convert(8'h80, 2, 1'b1, 1'b0);
    convert(8'h7F, 1, 1'b0, 1'b1);
    convert(8'hA5, 0, 1'b1, 1'b1);
    convert(8'h5A, 3, 1'b0, 1'b0);
    convert(8'h01, 0, 1'b0, 1'b1);
    convert(8'hFE, 1, 1'b1, 1'b1);
    convert(8'h33, 0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule